// File: doc/BRIEF.md
# Two-Switch Binary Stopwatch

This block measures elapsed time in seconds and minutes from the board clock. A built-in prescaler divides the clock into a one-cycle tick, one per second. Seconds are shown as a 6-bit binary value and minutes as a 2-bit binary value, eight LED lines in all. Seconds count 0 to 59. Minutes count modulo 4.

Two level-sensitive switches drive a three-state controller. The states are CLEAR (00), COUNT (01) and HOLD (10). The transitions are:
- CLEAR to COUNT when the start switch turns on.
- COUNT to HOLD when the stop switch turns on.
- HOLD back to COUNT when the stop switch turns off.
- Any state to CLEAR when the start switch turns off.

The state register is driven onto a 2-bit debug port so that the controller can be observed outside the device. The prescaler is held at zero in CLEAR, runs in COUNT and is frozen in HOLD. This means a paused fraction of a second is kept when counting resumes.

Top module: `stopwatch_core`

## Requirements
- R1: The seconds output `led_sec` is plain binary and never exceeds 59. A tick at 59 returns it to 0.
- R2: The minutes output `led_min` increments by one on every seconds wrap from 59 to 0. It wraps from 3 to 0.
- R3: `dbg_state` carries the state code: CLEAR = 2'b00, COUNT = 2'b01, HOLD = 2'b10. The code 2'b11 never appears.
- R4: In CLEAR with `sw_start` on, the state becomes COUNT at the next edge. `sw_stop` has no effect in CLEAR.
- R5: In COUNT with `sw_start` on and `sw_stop` on, the state becomes HOLD at the next edge. In HOLD the seconds, minutes and prescaler do not change.
- R6: In HOLD with `sw_start` on and `sw_stop` off, the state returns to COUNT. Counting resumes from the held seconds, minutes and prescaler phase.
- R7: With `sw_start` off, the state becomes CLEAR at the next edge, whatever the current state. This transition takes priority over `sw_stop`.
- R8: While the state is CLEAR, seconds and minutes are forced to zero at the next edge and the prescaler is held at zero.
- R9: In COUNT, seconds advance once every `TICK_DIV` clock edges. The first advance comes `TICK_DIV` edges after the state changes to COUNT.
- R10: An active-low asynchronous reset puts the block in CLEAR with seconds, minutes and the prescaler at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Start switch level: on leaves CLEAR, off returns to CLEAR |
| sw_stop | input | 1 | Stop switch level: on freezes the count, off resumes it |
| led_sec | output | SEC_W (6) | Elapsed seconds, binary |
| led_min | output | MIN_W (2) | Elapsed minutes, binary, modulo 4 |
| dbg_state | output | 2 | Controller state code |

## Verification
The bound checker watches every cycle for the following:
- the seconds range and the state encoding;
- each controller transition;
- the zeroing in CLEAR and the freeze in HOLD;
- the minute carry when seconds wrap at 59.

Some behaviours depend on how many edges pass between events, and only the bench scenarios can show them: the prescaler phase surviving a pause, the prescaler restarting after CLEAR, the exact tick spacing, and the modulo-4 minute wrap after four full minutes.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'b00,
        ST_COUNT = 2'b01,
        ST_HOLD  = 2'b10
    } sw_state_e;

endpackage

// File: rtl/stopwatch_tick_div.sv
// One-cycle tick every DIV enabled cycles; cleared to phase zero by clr.
module stopwatch_tick_div #(
    parameter int DIV = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + CW'(1);
        end
    end

    assign tick = en && (phase_q == LAST);

endmodule

// File: rtl/stopwatch_wrap_cnt.sv
// Counter that returns to zero after MOD-1; synchronous clear wins over inc.
module stopwatch_wrap_cnt #(
    parameter int W   = 6,
    parameter int MOD = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (clr) begin
            value_q <= '0;
        end else if (inc) begin
            value_q <= (value_q == LAST) ? '0 : value_q + W'(1);
        end
    end

    assign value = value_q;

endmodule

// File: rtl/stopwatch_ctrl.sv
// Clear / count / hold controller driven by two level switches.
module stopwatch_ctrl
    import stopwatch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_start,
    input  logic      sw_stop,
    output logic      run_en,
    output logic      clr,
    output sw_state_e state
);
    sw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (sw_start) state_d = ST_COUNT;
            ST_COUNT: begin
                if (!sw_start)    state_d = ST_CLEAR;
                else if (sw_stop) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!sw_start)     state_d = ST_CLEAR;
                else if (!sw_stop) state_d = ST_COUNT;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        run_en = (state_q == ST_COUNT);
        clr    = (state_q == ST_CLEAR);
        state  = state_q;
    end

endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import stopwatch_pkg::*;
#(
    parameter int TICK_DIV = 125_000_000,
    parameter int SEC_W    = 6,
    parameter int MIN_W    = 2,
    parameter int SEC_MOD  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_start,
    input  logic             sw_stop,
    output logic [SEC_W-1:0] led_sec,
    output logic [MIN_W-1:0] led_min,
    output logic [1:0]       dbg_state
);
    localparam int             MIN_MOD  = 1 << MIN_W;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_MOD - 1);

    logic      run_en, clr, tick, sec_wrap;
    sw_state_e state;

    stopwatch_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_start (sw_start),
        .sw_stop  (sw_stop),
        .run_en   (run_en),
        .clr      (clr),
        .state    (state)
    );

    stopwatch_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (run_en),
        .tick  (tick)
    );

    stopwatch_wrap_cnt #(.W(SEC_W), .MOD(SEC_MOD)) u_sec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (tick),
        .value (led_sec)
    );

    assign sec_wrap = tick && (led_sec == SEC_LAST);

    stopwatch_wrap_cnt #(.W(MIN_W), .MOD(MIN_MOD)) u_min (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (sec_wrap),
        .value (led_min)
    );

    assign dbg_state = state;

endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk
    import stopwatch_pkg::*;
#(
    parameter int SEC_W   = 6,
    parameter int MIN_W   = 2,
    parameter int SEC_MOD = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_start,
    input logic             sw_stop,
    input logic [SEC_W-1:0] led_sec,
    input logic [MIN_W-1:0] led_min,
    input logic [1:0]       dbg_state
);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_MOD - 1);

    assert_sec_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        led_sec <= SEC_LAST);

    assert_min_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state == ST_COUNT && led_sec == SEC_LAST) |=>
        (led_sec == SEC_LAST ||
         (led_sec == '0 && led_min == MIN_W'($past(led_min) + 1'b1))));

    assert_state_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_state != 2'b11);

    assert_clear_to_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state == ST_CLEAR && sw_start) |=> dbg_state == ST_COUNT);

    assert_count_to_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state == ST_COUNT && sw_start && sw_stop) |=> dbg_state == ST_HOLD);

    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state == ST_HOLD) |=> ($stable(led_sec) && $stable(led_min)));

    assert_hold_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state == ST_HOLD && sw_start && !sw_stop) |=>
        (dbg_state == ST_COUNT && $stable(led_sec) && $stable(led_min)));

    assert_start_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_start |=> dbg_state == ST_CLEAR);

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state == ST_CLEAR) |=> (led_sec == '0 && led_min == '0));

endmodule

bind stopwatch_core stopwatch_core_chk #(
    .SEC_W   (SEC_W),
    .MIN_W   (MIN_W),
    .SEC_MOD (SEC_MOD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_start  (sw_start),
    .sw_stop   (sw_stop),
    .led_sec   (led_sec),
    .led_min   (led_min),
    .dbg_state (dbg_state)
);

// File: tb/stopwatch_core_test.sv
`timescale 1ns/1ps
module stopwatch_core_test;

    localparam int DIV  = 4;
    localparam int NVEC = 19;

    // {start, stop, edges[15:0], state[1:0], sec[5:0], min[1:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 16'd2,   2'b00, 6'd0,  2'd0},  // 0  R10 idle after reset
        {1'b1, 1'b0, 16'd1,   2'b01, 6'd0,  2'd0},  // 1  R4 clear->count
        {1'b1, 1'b0, 16'd8,   2'b01, 6'd2,  2'd0},  // 2  R9 two ticks
        {1'b1, 1'b1, 16'd1,   2'b10, 6'd2,  2'd0},  // 3  R5 count->hold
        {1'b1, 1'b1, 16'd20,  2'b10, 6'd2,  2'd0},  // 4  R5 frozen
        {1'b1, 1'b0, 16'd1,   2'b01, 6'd2,  2'd0},  // 5  R6 hold->count
        {1'b1, 1'b0, 16'd3,   2'b01, 6'd3,  2'd0},  // 6  R6 phase kept
        {1'b1, 1'b0, 16'd224, 2'b01, 6'd59, 2'd0},  // 7  R1 reach 59
        {1'b1, 1'b0, 16'd4,   2'b01, 6'd0,  2'd1},  // 8  R1 wrap, R2 carry
        {1'b1, 1'b0, 16'd480, 2'b01, 6'd0,  2'd3},  // 9  R2 minute 3
        {1'b1, 1'b0, 16'd236, 2'b01, 6'd59, 2'd3},  // 10 R2 at 3:59
        {1'b1, 1'b0, 16'd4,   2'b01, 6'd0,  2'd0},  // 11 R2 minute wrap
        {1'b1, 1'b0, 16'd20,  2'b01, 6'd5,  2'd0},  // 12 R9 spacing
        {1'b0, 1'b0, 16'd2,   2'b00, 6'd0,  2'd0},  // 13 R7 + R8 count->clear
        {1'b1, 1'b1, 16'd2,   2'b10, 6'd0,  2'd0},  // 14 R4 stop ignored in clear
        {1'b0, 1'b1, 16'd1,   2'b00, 6'd0,  2'd0},  // 15 R7 hold->clear
        {1'b0, 1'b1, 16'd3,   2'b00, 6'd0,  2'd0},  // 16 R4 stays clear
        {1'b1, 1'b0, 16'd4,   2'b01, 6'd0,  2'd0},  // 17 R8 prescaler zeroed
        {1'b1, 1'b0, 16'd1,   2'b01, 6'd1,  2'd0}   // 18 R9 first tick
    };

    function automatic string vec_tag(int i);
        case (i)
            0:          return "R10";
            1, 14, 16:  return "R4";
            3, 4:       return "R5";
            5, 6:       return "R6";
            7, 8:       return "R1";
            9, 10, 11:  return "R2";
            13, 15:     return "R7";
            17:         return "R8";
            default:    return "R9";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_start = 1'b0;
    logic       sw_stop = 1'b0;
    logic [5:0] led_sec;
    logic [1:0] led_min;
    logic [1:0] dbg_state;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stopwatch_core #(.TICK_DIV(DIV)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_start  (sw_start),
        .sw_stop   (sw_stop),
        .led_sec   (led_sec),
        .led_min   (led_min),
        .dbg_state (dbg_state)
    );

    task automatic check(string tag, logic [1:0] st, logic [5:0] s, logic [1:0] m);
        checks++;
        if (dbg_state !== st || led_sec !== s || led_min !== m) begin
            failures++;
            $display("FAIL %s state=%0d sec=%0d min=%0d expected state=%0d sec=%0d min=%0d",
                     tag, dbg_state, led_sec, led_min, st, s, m);
        end
    endtask

    task automatic step(logic st, logic sp, int n);
        sw_start = st;
        sw_stop  = sp;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", 2'b00, 6'd0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][27], VEC[i][26], int'(VEC[i][25:10]));
            check(vec_tag(i), VEC[i][9:8], VEC[i][7:2], VEC[i][1:0]);
        end

        // R10: reset in the middle of a count
        step(1'b1, 1'b0, 10);
        check("R9", 2'b01, 6'd3, 2'd0);
        rst_n = 1'b0;
        #1;
        check("R10", 2'b00, 6'd0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1);
        check("R10", 2'b01, 6'd0, 2'd0);
        step(1'b1, 1'b0, 3);
        check("R10", 2'b01, 6'd0, 2'd0);
        step(1'b1, 1'b0, 1);
        check("R10", 2'b01, 6'd1, 2'd0);

        // R5 and R6: pause mid-second and resume
        step(1'b1, 1'b0, 2);
        step(1'b1, 1'b1, 1);
        step(1'b1, 1'b1, 9);
        check("R5", 2'b10, 6'd1, 2'd0);
        step(1'b1, 1'b0, 1);
        step(1'b1, 1'b0, 1);
        check("R6", 2'b01, 6'd2, 2'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule